// File: doc/BRIEF.md
# Event Timer Comparator Channel with Message Interrupt Delivery

This block is one comparator channel of a high-precision event timer. It watches a free-running 64-bit main counter supplied from outside and signals an expiry when the counter equals the channel's comparator. Software reaches the channel through a 32-bit register port. The register port holds a configuration word, a 64-bit comparator and a 64-bit route word. Each of the two 64-bit words is read and written as two dwords.

Each expiry is delivered in one of two ways. The first is a wired interrupt on one of 32 lines, chosen by a route field. In level mode the line is held and a status bit is set. In edge mode the line gives a single-cycle pulse. The second is a message: one posted 32-bit memory write on a valid/ready master port. Its address comes from the upper half of the route word and its data from the lower half. Message delivery leaves both the status bit and the wired lines alone.

The channel window starts at 0x100 + 0x20 × `TIMER_IDX`. Within the window the offsets are:
- configuration: +0x00 (low) and +0x04 (high)
- comparator: +0x08 and +0x0C
- route word: +0x10 (data) and +0x14 (address)

Top module: `evt_timer_msi`

## Requirements
- R1: After reset, the four configuration fields read as follows. Configuration low reads 0x0000_0030, with 0x8000 added when `MSI_CAP` is 1. Configuration high reads 0x0000_0004. Both comparator dwords read 0xFFFF_FFFF, and both route dwords read 0. `int_sts`, `msi_valid` and `irq_out` are 0.
- R2: A write to configuration low changes only the bits in mask 0x7F4E. All other bits keep their value. Configuration high is read-only.
- R3: The comparator dwords (+0x08 low, +0x0C high) and route dwords (+0x10 data, +0x14 address) are written and read independently. A write to one half leaves the other half unchanged.
- R4: An expiry occurs in a cycle where `cnt` equals the comparator while timer enable (configuration bit 2) and `glb_en` are both 1. When configuration bit 8 is set, only the low 32 bits are compared.
- R5: With message delivery enabled (configuration bit 14), an expiry raises `msi_valid` in the next cycle. `msi_addr` then equals route bits 63:32 and `msi_data` equals route bits 31:0. Neither `int_sts` nor `irq_out` is touched.
- R6: With message delivery disabled and level mode selected (configuration bit 1 = 1), an expiry sets `int_sts`. It also holds `irq_out[k]` high, where k is configuration bits 13:9.
- R7: With message delivery disabled and edge mode selected (bit 1 = 0), an expiry pulses `irq_out[k]` for exactly one cycle and leaves `int_sts` unchanged.
- R8: A clear event clears `int_sts`. A clear event is an `int_clr` pulse, timer enable being 0, or `glb_en` being 0. The held line is released only when message delivery is disabled.
- R9: A configuration write that changes bit 14 from 0 to 1 first performs the clear action of R8, under the old configuration, and then stores the new value.
- R10: While `msi_valid` is high and `msi_ready` is low, `msi_valid`, `msi_addr` and `msi_data` hold. Expiries that occur while a write is outstanding produce exactly one follow-up write after acceptance, however many there were.
- R11: Accesses outside the channel window have no effect, and reads outside it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | 64 | Main counter value |
| glb_en | input | 1 | Global timer enable |
| int_clr | input | 1 | Software status clear strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| int_sts | output | 1 | Interrupt status bit |
| irq_out | output | NUM_LINES | Wired interrupt lines |
| msi_valid | output | 1 | Message write request |
| msi_ready | input | 1 | Message write accepted |
| msi_addr | output | 32 | Message write address |
| msi_data | output | 32 | Message write data |

## Verification
Register writes take effect at the clock edge that samples them. Reads are combinational, so they are checked at the falling edge after the write.

Expiry results depend on a single register stage. `int_sts`, `msi_valid` and the level line therefore appear one edge after the cycle in which `cnt` matched. The bench presents each counter value at a falling edge and checks at the next falling edge.

The edge-mode pulse is checked at that falling edge and again one cycle later, to confirm that it has gone. Message follow-ups are counted across explicit single-cycle `msi_ready` pulses.

// File: rtl/evt_timer_msi.sv
module evt_timer_msi #(
  parameter int ADDR_W    = 12,
  parameter int TIMER_IDX = 0,
  parameter int NUM_LINES = 32,
  parameter bit MSI_CAP   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [63:0]          cnt,
  input  logic                 glb_en,
  input  logic                 int_clr,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 int_sts,
  output logic [NUM_LINES-1:0] irq_out,
  output logic                 msi_valid,
  input  logic                 msi_ready,
  output logic [31:0]          msi_addr,
  output logic [31:0]          msi_data
);
  localparam int          RT_W    = $clog2(NUM_LINES);
  localparam logic [31:0] WMASK   = 32'h0000_7F4E;
  localparam logic [31:0] CFG_RST = 32'h0000_0030 | (MSI_CAP ? 32'h0000_8000 : 32'h0);
  localparam logic [31:0] CFG_HI  = 32'h0000_0004;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(32'h100 + 32'h20 * TIMER_IDX);

  logic [31:0] cfg_q;
  logic [63:0] cmp_q, route_q;
  logic        sts_q, line_q, pulse_q, mv_q, pend_q;
  logic [31:0] maddr_q, mdata_q;

  wire       in_win = (reg_addr[ADDR_W-1:5] == BASE[ADDR_W-1:5]);
  wire [4:0] off    = reg_addr[4:0];
  wire       wr     = reg_we & in_win;
  wire       cfg_we = wr & (off == 5'h00);

  wire msi_en = cfg_q[14];
  wire tmr_en = cfg_q[2];
  wire lvl    = cfg_q[1];
  wire m32    = cfg_q[8];
  wire [RT_W-1:0] route_sel = cfg_q[9 +: RT_W];

  wire match  = m32 ? (cnt[31:0] == cmp_q[31:0]) : (cnt == cmp_q);
  wire hit    = tmr_en & glb_en & match;
  wire msi_on = cfg_we & ~cfg_q[14] & reg_wdata[14];
  wire clr_ev = int_clr | ~tmr_en | ~glb_en | msi_on;
  wire fire   = hit & msi_en;
  wire accept = mv_q & msi_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RST;
      cmp_q   <= '1;
      route_q <= '0;
    end else if (wr) begin
      case (off)
        5'h00: cfg_q <= (cfg_q & ~WMASK) | (reg_wdata & WMASK);
        5'h08: cmp_q[31:0]    <= reg_wdata;
        5'h0C: cmp_q[63:32]   <= reg_wdata;
        5'h10: route_q[31:0]  <= reg_wdata;
        5'h14: route_q[63:32] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q   <= 1'b0;
      line_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit & ~msi_en & ~lvl;
      if (hit && !msi_en && lvl) begin
        sts_q  <= 1'b1;
        line_q <= 1'b1;
      end else if (clr_ev) begin
        sts_q <= 1'b0;
        if (!msi_en) line_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_q    <= 1'b0;
      pend_q  <= 1'b0;
      maddr_q <= '0;
      mdata_q <= '0;
    end else if (!mv_q || accept) begin
      if (pend_q || fire) begin
        mv_q    <= 1'b1;
        maddr_q <= route_q[63:32];
        mdata_q <= route_q[31:0];
      end else begin
        mv_q <= 1'b0;
      end
      pend_q <= pend_q & fire;
    end else if (fire) begin
      pend_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_win) begin
      case (off)
        5'h00: reg_rdata = cfg_q;
        5'h04: reg_rdata = CFG_HI;
        5'h08: reg_rdata = cmp_q[31:0];
        5'h0C: reg_rdata = cmp_q[63:32];
        5'h10: reg_rdata = route_q[31:0];
        5'h14: reg_rdata = route_q[63:32];
        default: reg_rdata = '0;
      endcase
    end
  end

  assign int_sts   = sts_q;
  assign irq_out   = (line_q | pulse_q) ? (NUM_LINES'(1) << route_sel) : '0;
  assign msi_valid = mv_q;
  assign msi_addr  = maddr_q;
  assign msi_data  = mdata_q;

  a_r2_ro_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ((reg_rdata & 32'h0) == 32'h0) && (((cfg_q ^ $past(cfg_q)) & ~WMASK) == 32'h0));

  a_r5_msi_no_status: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !int_clr) |=> (int_sts == $past(int_sts)) && msi_valid);

  a_r6_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !msi_en && lvl) |=> int_sts && (irq_out != '0));

  a_r7_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_out));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_clr || !glb_en) && !hit) |=> !int_sts);

  a_r9_msi_enable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_on && !hit) |=> !int_sts && (irq_out == '0));

  a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !msi_ready) |=> msi_valid && $stable(msi_addr) && $stable(msi_data));
endmodule

// File: tb/test_evt_timer_msi.sv
module test_evt_timer_msi;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        glb_en = 1'b0, int_clr = 1'b0, reg_we = 1'b0, msi_ready = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, msi_addr, msi_data;
  logic        int_sts, msi_valid;
  logic [31:0] irq_out;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  evt_timer_msi #(.ADDR_W(12), .TIMER_IDX(0), .NUM_LINES(32), .MSI_CAP(1'b1)) i_evt_timer_msi (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .glb_en(glb_en), .int_clr(int_clr),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .int_sts(int_sts), .irq_out(irq_out), .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_addr(msi_addr), .msi_data(msi_data));

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b1, 12'h100, 32'hFFFF_FFFF, 32'h0000_FF7E},
    '{1'b1, 12'h100, 32'h0000_0000, 32'h0000_8030},
    '{1'b1, 12'h104, 32'hFFFF_FFFF, 32'h0000_0004},
    '{1'b1, 12'h108, 32'h1234_5678, 32'h1234_5678},
    '{1'b1, 12'h10C, 32'h9ABC_DEF0, 32'h9ABC_DEF0},
    '{1'b1, 12'h110, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{1'b1, 12'h114, 32'hFEE0_0000, 32'hFEE0_0000},
    '{1'b1, 12'h110, 32'h0000_0055, 32'h0000_0055},
    '{1'b0, 12'h114, 32'h0,         32'hFEE0_0000},
    '{1'b0, 12'h108, 32'h0,         32'h1234_5678},
    '{1'b1, 12'h080, 32'hFFFF_FFFF, 32'h0000_0000},
    '{1'b1, 12'h120, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic hit_at(input logic [63:0] v);
    @(negedge clk);
    cnt = v;
    @(negedge clk);
    cnt = v + 64'd1;
  endtask

  task automatic pulse_ready();
    @(negedge clk);
    msi_ready = 1'b1;
    @(negedge clk);
    msi_ready = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    int_clr = 1'b1;
    @(negedge clk);
    int_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(12'h100, d); check("R1 cfg lo", d, 32'h0000_8030);
    rd(12'h104, d); check("R1 cfg hi", d, 32'h0000_0004);
    rd(12'h108, d); check("R1 cmp lo", d, 32'hFFFF_FFFF);
    rd(12'h10C, d); check("R1 cmp hi", d, 32'hFFFF_FFFF);
    rd(12'h110, d); check("R1 route lo", d, 32'h0);
    check("R1 outputs", {int_sts, msi_valid, irq_out}, '0);

    for (int i = 0; i < 12; i++) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].wd);
      rd(VECS[i].addr, d);
      check($sformatf("R2/R3/R11 vec %0d", i), d, VECS[i].exp);
    end

    // R5: message delivery, route hi 0xFEE00000 lo 0x55
    wr(12'h108, 32'd100); wr(12'h10C, 32'd0);
    glb_en = 1'b1;
    wr(12'h100, 32'h0000_4006);
    hit_at(64'd100);
    check("R5 valid", msi_valid, 1);
    check("R5 addr", msi_addr, 32'hFEE0_0000);
    check("R5 data", msi_data, 32'h55);
    check("R5 no sts/line", {int_sts, irq_out}, '0);
    // R10: two further expiries while outstanding -> one follow-up only
    hit_at(64'd100);
    hit_at(64'd100);
    check("R10 held", {msi_valid, msi_addr}, {1'b1, 32'hFEE0_0000});
    pulse_ready();
    check("R10 follow-up", msi_valid, 1);
    pulse_ready();
    @(negedge clk);
    check("R10 no extra", msi_valid, 0);

    // R6 level, route 5
    wr(12'h100, 32'h0000_0A06);
    hit_at(64'd100);
    check("R6 sts", int_sts, 1);
    check("R6 line", irq_out, 32'h20);
    @(negedge clk);
    check("R6 held", irq_out, 32'h20);
    pulse_clr();
    check("R8 int_clr", {int_sts, irq_out}, '0);

    // R9 enabling message clears pending line
    hit_at(64'd100);
    check("R9 pre", int_sts, 1);
    wr(12'h100, 32'h0000_4A06);
    check("R9 cleared", {int_sts, irq_out}, '0);

    // R8 global disable clears
    wr(12'h100, 32'h0000_0A06);
    hit_at(64'd100);
    @(negedge clk); glb_en = 1'b0;
    @(negedge clk); glb_en = 1'b1;
    check("R8 glb off", {int_sts, irq_out}, '0);

    // R7 edge, route 3
    wr(12'h100, 32'h0000_0604);
    hit_at(64'd100);
    check("R7 pulse", irq_out, 32'h8);
    check("R7 no sts", int_sts, 0);
    @(negedge clk);
    check("R7 pulse ends", irq_out, 32'h0);

    // R4 disabled timer and global off give no expiry
    wr(12'h100, 32'h0000_0A02);
    hit_at(64'd100);
    check("R4 timer off", int_sts, 0);
    wr(12'h100, 32'h0000_0A06);
    glb_en = 1'b0;
    hit_at(64'd100);
    check("R4 glb off", int_sts, 0);
    glb_en = 1'b1;

    // R4 32-bit mode compares low half only
    wr(12'h108, 32'd200); wr(12'h10C, 32'd1);
    wr(12'h100, 32'h0000_0B06);
    hit_at({32'd7, 32'd200});
    check("R4 32-bit hit", int_sts, 1);
    pulse_clr();
    wr(12'h100, 32'h0000_0A06);
    hit_at({32'd7, 32'd200});
    check("R4 64-bit miss", int_sts, 0);
    hit_at({32'd1, 32'd200});
    check("R4 64-bit hit", int_sts, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule